// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block models the device side of the status readout of a NOR-style flash part. While the part runs an internal program or erase operation, a read returns a status byte instead of array contents. The status byte carries three flags. Bit 7 is the data-polling flag. Bit 6 is an operation toggle that flips on every read while an operation is active. Bit 2 is a sector toggle that flips only for reads that fall inside sectors selected for erase. With these flags a host can tell that an operation is still busy, that it has finished, and that an erase is suspended. When no operation is running, reads return the array byte supplied on an input port. Command decoding, the array itself and the real operation timing lie outside the block. The surrounding logic signals the start, suspend, resume and completion of an operation through single-cycle pulses.

A controller built around enumerated states tracks the operation: `IDLE`, `PROGRAM`, `ERASE`, `SUSPEND` (erase suspended), `SUSPEND_PROGRAM` (a program issued during an erase suspend), `GUARD_PROGRAM` and `GUARD_ERASE`. The two guard states show busy status for a fixed time when the operation hits protected sectors and cannot proceed. The transitions are:
- `start_program` leaves `IDLE` for `PROGRAM`, or for `GUARD_PROGRAM` when the target sector is protected.
- `start_erase` leaves `IDLE` for `ERASE`, or for `GUARD_ERASE` when every selected sector is protected.
- `done` returns `PROGRAM` and `ERASE` to `IDLE`, and returns `SUSPEND_PROGRAM` to `SUSPEND`.
- `suspend` takes `ERASE` to `SUSPEND`.
- `resume` takes `SUSPEND` back to `ERASE`.
- `suspend_program` takes `SUSPEND` to `SUSPEND_PROGRAM`.
- `guard_expired` returns either guard state to `IDLE`.

The guard times are counted in clock cycles and derived from the clock frequency in MHz.

Top module: `flash_status_responder`

## Requirements
- R1: After reset `rd_data` is 0. A read event in `IDLE` loads `rd_data` with `array_data` at that clock edge. `rd_data` holds its value between read events. Pulses of `op_done`, `susp_req` or `resume_req` in `IDLE` are ignored.
- R2: The status byte has the poll flag at bit 7, the operation toggle at bit 6 and the sector toggle at bit 2; all other bits are 0. In `PROGRAM`, `SUSPEND_PROGRAM` and `GUARD_PROGRAM`, bit 7 is the inverse of bit 7 of the datum latched at program start when the read address equals the latched program address, and 0 at any other address. After `op_done`, reads return `array_data`.
- R3: In `ERASE` and `GUARD_ERASE`, bit 7 of every status read is 0.
- R4: Bit 6 inverts on each read event in `PROGRAM`, `ERASE`, `SUSPEND_PROGRAM`, `GUARD_PROGRAM` and `GUARD_ERASE`, and holds in `IDLE` and `SUSPEND`. Both toggles clear to 0 when an operation is accepted, even when a read event falls in the same cycle, so the first busy read shows bit 6 = 1.
- R5: A sector is selected by the top `SECT_BITS` bits of the address. Bit 2 inverts on a read event whose address lies in a sector of the latched erase selection while in `ERASE`, `SUSPEND` or `GUARD_ERASE`. It holds for every other read.
- R6: In `SUSPEND`, a read inside a selected sector returns status with bit 7 = 1 and bit 6 held. A read outside the selection returns `array_data`.
- R7: `susp_req` moves `ERASE` to `SUSPEND`, and `resume_req` moves `SUSPEND` back to `ERASE`. A program start in `SUSPEND` enters `SUSPEND_PROGRAM`, whose `op_done` returns to `SUSPEND`. A program start in `SUSPEND` aimed at a protected sector is ignored. When `resume_req` and a program start fall in the same cycle, `resume_req` wins.
- R8: A program start in `IDLE` aimed at a protected sector shows program busy status for exactly `CLK_MHZ*PROG_GUARD_US` cycles and then returns to `IDLE`. `op_done` has no effect during that time.
- R9: An erase start in `IDLE` whose selected sectors are all protected shows erase busy status for exactly `CLK_MHZ*ERASE_GUARD_US` cycles and then returns to `IDLE`. If at least one selected sector is unprotected, a normal erase runs until `op_done`.
- R10: A read event is a rising edge of the active-high condition `rd_oe & rd_ce`, so either strobe can pace reads while the other is held high. A strobe held high produces exactly one read event.
- R11: In `ERASE`, an `op_done` in the same cycle as `susp_req` ends the erase (`IDLE`). Start pulses are ignored in every state other than `IDLE` and `SUSPEND`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Single-cycle pulse that starts an operation |
| op_is_erase | input | 1 | Operation type qualifying `op_start`: 1 erase, 0 program |
| op_done | input | 1 | Single-cycle pulse that ends the running program or erase |
| susp_req | input | 1 | Erase suspend pulse |
| resume_req | input | 1 | Erase resume pulse |
| prog_addr | input | ADDR_W | Program target address, sampled at start |
| prog_data | input | 8 | Datum being programmed, sampled at start |
| erase_sel | input | 2**SECT_BITS | Sectors selected for erase, sampled at start |
| sect_prot | input | 2**SECT_BITS | Per-sector protect flags |
| rd_oe | input | 1 | Output-enable read strobe, active high |
| rd_ce | input | 1 | Chip-enable read strobe, active high |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | 8 | Array byte for reads that return data |
| rd_data | output | 8 | Byte captured at the last read event |

## Verification
Several events can coincide on one clock edge. A read event can coincide with an operation start, in which case the toggle clear must beat the flip. It can coincide with a state change, in which case the byte must reflect the state before the edge. `op_done` can arrive together with `susp_req`, and `resume_req` can arrive together with a program start in suspend. The bench drives each of these pairs on the same negative edge. A behavioural model advances its mode and toggles in the stated order of priority and predicts the byte, and the bench compares that prediction with `rd_data` on every clock. Directed reads that follow each collision confirm the toggle values and the state that resulted.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int BYTE_W       = 8;
    localparam int POLL_BIT     = 7;
    localparam int OP_TGL_BIT   = 6;
    localparam int SECT_TGL_BIT = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_SPROG,
        ST_GPROG,
        ST_GERASE
    } fsr_state_e;

    function automatic logic [BYTE_W-1:0] make_status(
        input logic poll,
        input logic op_tgl,
        input logic sect_tgl
    );
        logic [BYTE_W-1:0] b;
        b               = '0;
        b[POLL_BIT]     = poll;
        b[OP_TGL_BIT]   = op_tgl;
        b[SECT_TGL_BIT] = sect_tgl;
        return b;
    endfunction

endpackage

// File: rtl/fsr_read_edge.sv
module fsr_read_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_a,
    input  logic strobe_b,
    output logic rd_ev
);

    logic level;
    logic level_q;

    assign level = strobe_a & strobe_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    assign rd_ev = level & ~level_q;

    // A held strobe yields one event only
    AST_HELD_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ev |=> !rd_ev); // R10

endmodule

// File: rtl/fsr_sector_map.sv
module fsr_sector_map #(
    parameter int SECT_BITS = 3,
    localparam int NSECT = 1 << SECT_BITS
) (
    input  logic [SECT_BITS-1:0] rd_sect,
    input  logic [SECT_BITS-1:0] pg_sect,
    input  logic [NSECT-1:0]     sel_mask,
    input  logic [NSECT-1:0]     prot_mask,
    output logic                 rd_in_sel,
    output logic                 pg_prot
);

    logic [NSECT-1:0] rd_hit;
    logic [NSECT-1:0] pg_hit;

    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        assign rd_hit[s] = (rd_sect == SECT_BITS'(s)) && sel_mask[s];
        assign pg_hit[s] = (pg_sect == SECT_BITS'(s)) && prot_mask[s];
    end

    assign rd_in_sel = |rd_hit;
    assign pg_prot   = |pg_hit;

endmodule

// File: rtl/fsr_guard_timer.sv
module fsr_guard_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    AST_GUARD_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R8

    AST_GUARD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !zero); // R9

endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
    import fsr_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int SECT_BITS      = 3,
    parameter int CLK_MHZ        = 10,
    parameter int PROG_GUARD_US  = 2,
    parameter int ERASE_GUARD_US = 100,
    localparam int NSECT = 1 << SECT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_is_erase,
    input  logic              op_done,
    input  logic              susp_req,
    input  logic              resume_req,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic [NSECT-1:0]  erase_sel,
    input  logic [NSECT-1:0]  sect_prot,
    input  logic              rd_oe,
    input  logic              rd_ce,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        array_data,
    output logic [7:0]        rd_data
);

    localparam int PROG_CYC  = CLK_MHZ * PROG_GUARD_US;
    localparam int ERASE_CYC = CLK_MHZ * ERASE_GUARD_US;
    localparam int MAX_CYC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    fsr_state_e         st_q, st_d;
    logic               rd_ev;
    logic               rd_in_sel;
    logic               pg_prot;
    logic               erase_all_prot;
    logic               start_idle;
    logic               start_susp;
    logic               started;
    logic               guard_load;
    logic [CNT_W-1:0]   guard_val;
    logic               guard_zero;
    logic               tgl6_q, tgl6_d;
    logic               tgl2_q, tgl2_d;
    logic               pd7_q;
    logic [ADDR_W-1:0]  paddr_q;
    logic [NSECT-1:0]   sel_q;
    logic               addr_match;
    logic               op_busy;
    logic               sect_live;
    logic               unused_prog_low;

    assign unused_prog_low = ^prog_data[BYTE_W-2:0];

    fsr_read_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_a (rd_oe),
        .strobe_b (rd_ce),
        .rd_ev    (rd_ev)
    );

    fsr_sector_map #(.SECT_BITS(SECT_BITS)) u_map (
        .rd_sect   (rd_addr[ADDR_W-1 -: SECT_BITS]),
        .pg_sect   (prog_addr[ADDR_W-1 -: SECT_BITS]),
        .sel_mask  (sel_q),
        .prot_mask (sect_prot),
        .rd_in_sel (rd_in_sel),
        .pg_prot   (pg_prot)
    );

    assign erase_all_prot = ((erase_sel & ~sect_prot) == '0);
    assign start_idle     = (st_q == ST_IDLE) && op_start;
    assign start_susp     = (st_q == ST_SUSP) && op_start && !op_is_erase
                            && !pg_prot && !resume_req;
    assign started        = start_idle || start_susp;

    assign guard_load = start_idle && (op_is_erase ? erase_all_prot : pg_prot);
    assign guard_val  = op_is_erase ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);

    fsr_guard_timer #(.CNT_W(CNT_W)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (guard_load),
        .load_val (guard_val),
        .zero     (guard_zero)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (op_start) begin
                    if (op_is_erase) begin
                        st_d = erase_all_prot ? ST_GERASE : ST_ERASE;
                    end else begin
                        st_d = pg_prot ? ST_GPROG : ST_PROG;
                    end
                end
            end
            ST_PROG: begin
                if (op_done) st_d = ST_IDLE;
            end
            ST_ERASE: begin
                if (op_done)       st_d = ST_IDLE;
                else if (susp_req) st_d = ST_SUSP;
            end
            ST_SUSP: begin
                if (resume_req)      st_d = ST_ERASE;
                else if (start_susp) st_d = ST_SPROG;
            end
            ST_SPROG: begin
                if (op_done) st_d = ST_SUSP;
            end
            ST_GPROG, ST_GERASE: begin
                if (guard_zero) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // operation context latched at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd7_q   <= 1'b0;
            paddr_q <= '0;
            sel_q   <= '0;
        end else begin
            if (started && !op_is_erase) begin
                pd7_q   <= prog_data[POLL_BIT];
                paddr_q <= prog_addr;
            end
            if (start_idle && op_is_erase) begin
                sel_q <= erase_sel;
            end
        end
    end

    // toggle bits
    assign op_busy   = st_q inside {ST_PROG, ST_ERASE, ST_SPROG, ST_GPROG, ST_GERASE};
    assign sect_live = (st_q inside {ST_ERASE, ST_SUSP, ST_GERASE}) && rd_in_sel;

    always_comb begin
        tgl6_d = tgl6_q;
        tgl2_d = tgl2_q;
        if (started) begin
            tgl6_d = 1'b0;
            tgl2_d = 1'b0;
        end else if (rd_ev) begin
            if (op_busy)   tgl6_d = ~tgl6_q;
            if (sect_live) tgl2_d = ~tgl2_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl6_q <= 1'b0;
            tgl2_q <= 1'b0;
        end else begin
            tgl6_q <= tgl6_d;
            tgl2_q <= tgl2_d;
        end
    end

    assign addr_match = (rd_addr == paddr_q);

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_ev) begin
            unique case (st_q)
                ST_IDLE:
                    rd_data <= array_data;
                ST_PROG, ST_SPROG, ST_GPROG:
                    rd_data <= make_status(addr_match & ~pd7_q, tgl6_d, tgl2_d);
                ST_ERASE, ST_GERASE:
                    rd_data <= make_status(1'b0, tgl6_d, tgl2_d);
                ST_SUSP:
                    rd_data <= rd_in_sel ? make_status(1'b1, tgl6_d, tgl2_d) : array_data;
                default:
                    rd_data <= array_data;
            endcase
        end
    end

    AST_IDLE_READ_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ev && st_q == ST_IDLE) |=> (rd_data == $past(array_data))); // R1

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ev && (st_q inside {ST_ERASE, ST_GERASE})) |=> !rd_data[POLL_BIT]); // R3

    AST_BUSY_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ev && op_busy) |=> (rd_data[OP_TGL_BIT] != $past(tgl6_q))); // R4

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q inside {ST_IDLE, ST_SUSP}) && !started) |=> $stable(tgl6_q)); // R4

    AST_SUSP_POLL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ev && st_q == ST_SUSP && rd_in_sel && !started) |=> rd_data[POLL_BIT]); // R6

    AST_DONE_BEATS_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ERASE && op_done) |=> (st_q == ST_IDLE)); // R11

    AST_GUARD_IGNORES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GPROG && !guard_zero) |=> (st_q == ST_GPROG)); // R8

endmodule

// File: tb/flash_status_responder_test.sv
module flash_status_responder_test;

    localparam int CLK_NS = 10;
    localparam int AW     = 8;
    localparam int SB     = 3;
    localparam int PCYC   = 20;
    localparam int ECYC   = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0, op_is_erase = 1'b0, op_done = 1'b0;
    logic       susp_req = 1'b0, resume_req = 1'b0;
    logic [7:0] prog_addr = '0, prog_data = '0;
    logic [7:0] erase_sel = '0, sect_prot = '0;
    logic       rd_oe = 1'b0, rd_ce = 1'b0;
    logic [7:0] rd_addr = '0, array_data = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    flash_status_responder #(
        .ADDR_W(AW), .SECT_BITS(SB), .CLK_MHZ(10),
        .PROG_GUARD_US(2), .ERASE_GUARD_US(100)
    ) uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
        .op_done(op_done), .susp_req(susp_req), .resume_req(resume_req),
        .prog_addr(prog_addr), .prog_data(prog_data), .erase_sel(erase_sel),
        .sect_prot(sect_prot), .rd_oe(rd_oe), .rd_ce(rd_ce), .rd_addr(rd_addr),
        .array_data(array_data), .rd_data(rd_data)
    );

    // ---------------- behavioural reference ----------------
    // modes: 0 idle, 1 program, 2 erase, 3 suspended, 4 suspend-program,
    //        5 guarded program, 6 guarded erase
    int         m_mode = 0;
    int         m_left = 0;
    bit         m_t6 = 0, m_t2 = 0, m_pd7 = 0, m_prev = 0;
    logic [7:0] m_paddr = '0, m_sel = '0;
    logic [7:0] m_exp = '0;

    function automatic string tag_of(input int md);
        case (md)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_t6 = 0; m_t2 = 0; m_pd7 = 0; m_prev = 0;
            m_paddr = '0; m_sel = '0; m_exp = '0;
        end else begin
            bit ev, acc, insel, blocked, allprot;
            int nxt;
            ev      = (rd_oe && rd_ce) && !m_prev;
            m_prev  = rd_oe && rd_ce;
            insel   = m_sel[rd_addr[7:5]];
            blocked = sect_prot[prog_addr[7:5]];
            allprot = ((erase_sel & ~sect_prot) == 8'h00);
            nxt     = m_mode;
            acc     = 0;
            if (m_mode == 0 && op_start) begin
                acc = 1;
                if (op_is_erase) nxt = allprot ? 6 : 2;
                else             nxt = blocked ? 5 : 1;
            end else if (m_mode == 3 && op_start && !op_is_erase && !blocked && !resume_req) begin
                acc = 1;
                nxt = 4;
            end
            if (acc) begin
                m_t6 = 0; m_t2 = 0;
            end else if (ev) begin
                if (m_mode inside {1, 2, 4, 5, 6}) m_t6 = !m_t6;
                if ((m_mode inside {2, 3, 6}) && insel) m_t2 = !m_t2;
            end
            if (ev) begin
                case (m_mode)
                    0: m_exp = array_data;
                    1, 4, 5: m_exp = {(rd_addr == m_paddr) && !m_pd7, m_t6, 3'b000, m_t2, 2'b00};
                    2, 6: m_exp = {1'b0, m_t6, 3'b000, m_t2, 2'b00};
                    default: m_exp = insel ? {1'b1, m_t6, 3'b000, m_t2, 2'b00} : array_data;
                endcase
            end
            case (m_mode)
                1: if (op_done) nxt = 0;
                2: if (op_done) nxt = 0; else if (susp_req) nxt = 3;
                3: if (resume_req) nxt = 2;
                4: if (op_done) nxt = 3;
                5, 6: if (m_left == 0) nxt = 0; else m_left = m_left - 1;
                default: ;
            endcase
            if (acc && !op_is_erase) begin
                m_pd7 = prog_data[7];
                m_paddr = prog_addr;
            end
            if (m_mode == 0 && op_start && op_is_erase) m_sel = erase_sel;
            if (m_mode == 0 && nxt == 5) m_left = PCYC - 1;
            if (m_mode == 0 && nxt == 6) m_left = ECYC - 1;
            m_mode = nxt;
        end
    end

    always begin
        @(posedge clk);
        #(CLK_NS/4);
        if (rst_n && !finished) begin
            checks++;
            if (rd_data !== m_exp) begin
                errors++;
                $display("FAIL %s per-cycle model: actual=%02h expected=%02h t=%0t",
                         tag_of(m_mode), rd_data, m_exp, $time);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] a, input bit via_ce);
        @(negedge clk);
        rd_addr = a; rd_oe = 1'b1; rd_ce = 1'b1;
        @(negedge clk);
        if (via_ce) rd_ce = 1'b0; else rd_oe = 1'b0;
    endtask

    task automatic strobes_off;
        @(negedge clk);
        rd_oe = 1'b0; rd_ce = 1'b0;
    endtask

    task automatic start_op(input bit er, input logic [7:0] pa, input logic [7:0] pd,
                            input logic [7:0] sel);
        @(negedge clk);
        op_start = 1'b1; op_is_erase = er; prog_addr = pa; prog_data = pd; erase_sel = sel;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic pulse_done;
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic pulse_susp;
        @(negedge clk); susp_req = 1'b1;
        @(negedge clk); susp_req = 1'b0;
    endtask

    task automatic pulse_resume;
        @(negedge clk); resume_req = 1'b1;
        @(negedge clk); resume_req = 1'b0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL R1: watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        check("R1 reset value", rd_data, 8'h00);

        // idle reads, ignored control pulses
        array_data = 8'h96;
        do_read(8'h10, 0);
        check("R1 idle read", rd_data, 8'h96);
        pulse_done(); pulse_susp(); pulse_resume();
        array_data = 8'h3B;
        cyc(2);
        check("R1 hold between reads", rd_data, 8'h96);
        do_read(8'hF0, 0);
        check("R1 idle read after ignored pulses", rd_data, 8'h3B);
        strobes_off();

        // normal program
        start_op(0, 8'h44, 8'h5A, 8'h00);
        do_read(8'h44, 0); check("R2 R4 first program read", rd_data, 8'hC0);
        do_read(8'h44, 0); check("R4 second program read", rd_data, 8'h80);
        do_read(8'h45, 0); check("R2 other address", rd_data, 8'h40);
        do_read(8'h44, 1); check("R10 oe-rise read", rd_data, 8'h80);
        do_read(8'h44, 1); check("R10 ce-paced read", rd_data, 8'hC0);
        @(negedge clk); rd_ce = 1'b1;
        cyc(3);
        check("R10 held strobe one event", rd_data, 8'h80);
        @(negedge clk); rd_ce = 1'b0;
        do_read(8'h44, 0); check("R10 next read after hold", rd_data, 8'hC0);
        strobes_off();
        pulse_done();
        array_data = 8'h5A;
        do_read(8'h44, 0); check("R2 true data after done", rd_data, 8'h5A);
        strobes_off();

        // erase, suspend, suspend-program, resume
        array_data = 8'h3C;
        start_op(1, 8'h00, 8'h00, 8'h0A);
        do_read(8'h20, 0); check("R3 R5 erase read in sector", rd_data, 8'h44);
        do_read(8'h00, 0); check("R5 erase read outside", rd_data, 8'h04);
        do_read(8'h60, 0); check("R5 erase read other sector", rd_data, 8'h40);
        strobes_off();
        pulse_susp();
        do_read(8'h25, 0); check("R6 suspended in sector", rd_data, 8'hC4);
        do_read(8'h00, 0); check("R6 suspended outside", rd_data, 8'h3C);
        do_read(8'h30, 0); check("R5 suspended sector toggle", rd_data, 8'hC0);
        strobes_off();
        sect_prot = 8'h10;
        start_op(0, 8'h90, 8'h00, 8'h0A);
        do_read(8'h00, 0); check("R7 protected suspend program ignored", rd_data, 8'h3C);
        do_read(8'h20, 0); check("R7 toggles kept", rd_data, 8'hC4);
        strobes_off();
        sect_prot = 8'h00;
        start_op(0, 8'h80, 8'hFF, 8'h0A);
        do_read(8'h80, 0); check("R7 R4 suspend program read", rd_data, 8'h40);
        do_read(8'h80, 0); check("R7 suspend program toggles", rd_data, 8'h00);
        strobes_off();
        pulse_done();
        do_read(8'h20, 0); check("R7 back in suspend", rd_data, 8'h84);
        strobes_off();
        pulse_resume();
        do_read(8'h20, 0); check("R7 resumed erase", rd_data, 8'h40);
        strobes_off();
        @(negedge clk); op_done = 1'b1; susp_req = 1'b1;
        @(negedge clk); op_done = 1'b0; susp_req = 1'b0;
        array_data = 8'hA5;
        do_read(8'h20, 0); check("R11 done beats suspend", rd_data, 8'hA5);
        strobes_off();

        // resume and program start in the same cycle during suspend
        start_op(1, 8'h00, 8'h00, 8'h02);
        pulse_susp();
        @(negedge clk);
        resume_req = 1'b1; op_start = 1'b1; op_is_erase = 1'b0; prog_addr = 8'h80;
        @(negedge clk);
        resume_req = 1'b0; op_start = 1'b0;
        do_read(8'h80, 0); check("R7 resume wins", rd_data, 8'h40);
        strobes_off();
        pulse_done();

        // guarded program
        sect_prot = 8'h10;
        start_op(0, 8'h90, 8'h00, 8'h00);
        do_read(8'h90, 0); check("R8 guarded program busy", rd_data, 8'hC0);
        strobes_off();
        pulse_done();
        cyc(6);
        do_read(8'h90, 0); check("R8 done ignored while guarded", rd_data, 8'h80);
        strobes_off();
        cyc(20);
        array_data = 8'h11;
        do_read(8'h90, 0); check("R8 guard expired", rd_data, 8'h11);
        strobes_off();

        // read in the same cycle as a start
        sect_prot = 8'h00;
        array_data = 8'h77;
        @(negedge clk);
        op_start = 1'b1; op_is_erase = 1'b0; prog_addr = 8'h44; prog_data = 8'h00;
        rd_addr = 8'h44; rd_oe = 1'b1; rd_ce = 1'b1;
        @(negedge clk);
        op_start = 1'b0; rd_oe = 1'b0;
        check("R4 read with start sees idle", rd_data, 8'h77);
        do_read(8'h44, 0); check("R4 toggle cleared at start", rd_data, 8'hC0);
        strobes_off();
        pulse_done();

        // guarded erase
        sect_prot = 8'h10;
        start_op(1, 8'h00, 8'h00, 8'h10);
        do_read(8'h90, 0); check("R9 guarded erase busy", rd_data, 8'h44);
        strobes_off();
        cyc(500);
        do_read(8'h90, 0); check("R9 guarded erase still busy", rd_data, 8'h00);
        strobes_off();
        cyc(600);
        array_data = 8'h22;
        do_read(8'h90, 0); check("R9 guarded erase expired", rd_data, 8'h22);
        strobes_off();

        // partly protected erase runs until done
        start_op(1, 8'h00, 8'h00, 8'h30);
        cyc(1100);
        do_read(8'hA0, 0); check("R9 partial erase still running", rd_data, 8'h44);
        strobes_off();
        pulse_done();
        array_data = 8'h5F;
        do_read(8'hA0, 0); check("R9 partial erase finished", rd_data, 8'h5F);
        strobes_off();

        // start ignored while busy
        sect_prot = 8'h00;
        start_op(0, 8'h44, 8'h80, 8'h00);
        start_op(1, 8'h00, 8'h00, 8'hFF);
        do_read(8'h44, 0); check("R11 start ignored while busy", rd_data, 8'h40);
        strobes_off();
        pulse_done();

        cyc(3);
        finished = 1;
        summary();
        $finish;
    end

endmodule